// File: doc/BRIEF.md
# Low Pin Count Bus Transaction Monitor

This block watches a 4-bit multiplexed address/data bus and its active-low frame strobe, one sample per bus clock. It never drives the bus. The monitor follows each target cycle field by field, from the framing nibble to the final bus turn-around. Every field it decodes comes out as a one-clock report on `fld_valid`, with a field kind and a value. Protocol violations raise one-clock warning pulses that line up with the report they concern.

Only I/O and memory reads and writes to a target are followed. A frame whose last framing nibble is not the target code is reported and then ignored. A cycle-type nibble outside the I/O and memory range is reported with a warning, and the monitor then goes back to idle. If the strobe drops in the middle of a transaction, the transaction is abandoned and decoding restarts at the framing field.

Each report appears on the outputs one clock after the edge that sampled the matching bus nibble. The monitor is meant to feed a logging or checking stage that turns the field stream into readable trace lines.

Top module: `lpc_txn_monitor`

## Requirements
- R1: While `rst` is high and on the first clock after it, every output is 0 and the monitor is idle.
- R2: Every clock sampled with `frame_n` low produces a START report (kind 0) whose value is the sampled nibble, so a strobe held low for several clocks gives one report per clock.
- R3: When two consecutive clocks both sample `frame_n` low with different nibbles, `warn_unstable` pulses together with the second START report.
- R4: Only the last nibble seen before the strobe returns high decides the frame. If that nibble is 0000, a target cycle follows. Any other value means nothing more is reported until the next strobe.
- R5: The first clock with `frame_n` high after a target frame is the cycle-type field (kind 1), reported with the raw nibble. Bit 3 = 0 is a valid type, bit 2 selects memory (1) or I/O (0), bit 1 selects write (1) or read (0), and bit 0 is ignored. With bit 3 = 1, `warn_badtype` pulses with the report and the monitor returns to idle.
- R6: The address is taken most significant nibble first: 4 nibbles for I/O and 8 for memory. It is reported once, on its last nibble, as kind 2, zero-extended to 32 bits.
- R7: Each turn-around is two clocks. Each clock is reported as kind 3 with value bit 4 = index (0 or 1) and bits 3:0 = the nibble. A nibble other than 1111 pulses `warn_turn` with that report.
- R8: Every SYNC clock is reported as kind 4, with bits 3:0 = the nibble and bits 11:4 = the SYNC clock index counted from 0 (saturating). The codes 0101 and 0110 keep the phase going. The codes 0000 and 1010 end it. Any other code pulses `warn_badsync` and the phase continues.
- R9: The data byte takes two clocks, low nibble first, and is reported once as kind 5 on the second clock.
- R10: A read runs address, turn-around, SYNC, data, turn-around. A write runs address, data, turn-around, SYNC, turn-around. After the second turn-around the monitor is idle and reports nothing while the strobe stays high.
- R11: If the strobe is sampled low in any field after the framing field, `abort_seen` pulses with the START report and decoding restarts at the framing field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Sampled active-low frame strobe |
| bus_nib | input | 4 | Sampled multiplexed bus nibble |
| fld_valid | output | 1 | One-clock field report strobe |
| fld_kind | output | 3 | Field kind: 0 start, 1 type, 2 address, 3 turn-around, 4 sync, 5 data |
| fld_value | output | 32 | Field value, packed per kind |
| warn_unstable | output | 1 | Nibble changed while the strobe stayed low |
| warn_badtype | output | 1 | Cycle type outside I/O and memory |
| warn_turn | output | 1 | Turn-around nibble not 1111 |
| warn_badsync | output | 1 | Reserved SYNC code |
| abort_seen | output | 1 | Transaction abandoned by a new strobe |

## Verification
The assertions take for granted that `frame_n` and `bus_nib` are clean bus-clock samples. They also assume that a strobe drop is always a genuine framing event, so it must produce a START report on the next clock. The stimulus drives both inputs one nanosecond after each rising edge, which keeps them constant across the sampling edge. Wait-state SYNC sequences are kept short, so the SYNC index never reaches saturation and its expected value can be computed by simple arithmetic. Random transactions only use valid cycle types and legal SYNC codes. Reserved codes, bad turn-arounds, changing framing nibbles and aborts are introduced only in the directed cases.

// File: rtl/lpc_mon_pkg.sv
package lpc_mon_pkg;

    localparam int NIB_W = 4;
    localparam int VAL_W = 32;
    localparam logic [NIB_W-1:0] TARGET_FRAME = 4'b0000;
    localparam logic [NIB_W-1:0] TURN_IDLE    = 4'b1111;

    typedef enum logic [2:0] {
        FK_START = 3'd0,
        FK_CTYPE = 3'd1,
        FK_ADDR  = 3'd2,
        FK_TURN  = 3'd3,
        FK_SYNC  = 3'd4,
        FK_DATA  = 3'd5
    } fld_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_ADDR,
        ST_TURN_A,
        ST_SYNC,
        ST_DATA,
        ST_TURN_B
    } walk_st_e;

    typedef enum logic [1:0] {
        SY_DONE,
        SY_WAIT,
        SY_RSVD
    } sync_cls_e;

    typedef struct packed {
        logic ok;
        logic mem;
        logic wr;
    } ctype_t;

    typedef struct packed {
        logic unstable;
        logic badtype;
        logic turn;
        logic badsync;
        logic abort;
    } warn_t;

    function automatic ctype_t decode_ctype(input logic [NIB_W-1:0] n);
        ctype_t c;
        c.ok  = ~n[3];
        c.mem = n[2];
        c.wr  = n[1];
        return c;
    endfunction

    function automatic sync_cls_e classify_sync(input logic [NIB_W-1:0] n);
        case (n)
            4'b0000, 4'b1010: return SY_DONE;
            4'b0101, 4'b0110: return SY_WAIT;
            default:          return SY_RSVD;
        endcase
    endfunction

endpackage

// File: rtl/lpc_mon_frame.sv
module lpc_mon_frame
    import lpc_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_nib,
    output logic             frame_act,
    output logic             nib_changed
);

    logic             prev_low;
    logic [NIB_W-1:0] prev_nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_low <= 1'b0;
            prev_nib <= '0;
        end else begin
            prev_low <= ~frame_n;
            prev_nib <= bus_nib;
        end
    end

    assign frame_act   = ~frame_n;
    assign nib_changed = ~frame_n & prev_low & (bus_nib != prev_nib);

endmodule

// File: rtl/lpc_mon_walker.sv
module lpc_mon_walker
    import lpc_mon_pkg::*;
#(
    parameter int IO_NIBBLES  = 4,
    parameter int MEM_NIBBLES = 8,
    parameter int SYNC_CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_act,
    input  logic             nib_changed,
    input  logic [NIB_W-1:0] bus_nib,
    output logic             fld_valid,
    output fld_kind_e        fld_kind,
    output logic [VAL_W-1:0] fld_value,
    output warn_t            warn
);

    localparam int CNT_W = (MEM_NIBBLES > 2) ? $clog2(MEM_NIBBLES) : 1;

    walk_st_e             st;
    logic                 is_mem;
    logic                 is_wr;
    logic [NIB_W-1:0]     start_nib;
    logic [CNT_W-1:0]     cnt;
    logic                 tidx;
    logic [SYNC_CNT_W-1:0] scnt;
    logic [VAL_W-1:0]     addr_sr;
    logic [NIB_W-1:0]     lo_nib;

    ctype_t               ct_now;
    sync_cls_e            sy_now;
    logic [CNT_W-1:0]     last_idx;
    logic [VAL_W-1:0]     addr_next;

    assign ct_now    = decode_ctype(bus_nib);
    assign sy_now    = classify_sync(bus_nib);
    assign last_idx  = is_mem ? CNT_W'(MEM_NIBBLES - 1) : CNT_W'(IO_NIBBLES - 1);
    assign addr_next = {addr_sr[VAL_W-NIB_W-1:0], bus_nib};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            is_mem    <= 1'b0;
            is_wr     <= 1'b0;
            start_nib <= '0;
            cnt       <= '0;
            tidx      <= 1'b0;
            scnt      <= '0;
            addr_sr   <= '0;
            lo_nib    <= '0;
            fld_valid <= 1'b0;
            fld_kind  <= FK_START;
            fld_value <= '0;
            warn      <= '0;
        end else begin
            fld_valid <= 1'b0;
            fld_kind  <= FK_START;
            fld_value <= '0;
            warn      <= '0;
            if (frame_act) begin
                fld_valid     <= 1'b1;
                fld_value     <= VAL_W'(bus_nib);
                warn.unstable <= nib_changed;
                warn.abort    <= (st != ST_IDLE) && (st != ST_FRAME);
                start_nib     <= bus_nib;
                st            <= ST_FRAME;
            end else begin
                case (st)
                    ST_FRAME: begin
                        if (start_nib != TARGET_FRAME) begin
                            st <= ST_IDLE;
                        end else begin
                            fld_valid <= 1'b1;
                            fld_kind  <= FK_CTYPE;
                            fld_value <= VAL_W'(bus_nib);
                            if (!ct_now.ok) begin
                                warn.badtype <= 1'b1;
                                st           <= ST_IDLE;
                            end else begin
                                is_mem  <= ct_now.mem;
                                is_wr   <= ct_now.wr;
                                cnt     <= '0;
                                addr_sr <= '0;
                                st      <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR: begin
                        addr_sr <= addr_next;
                        cnt     <= cnt + 1'b1;
                        if (cnt == last_idx) begin
                            fld_valid <= 1'b1;
                            fld_kind  <= FK_ADDR;
                            fld_value <= addr_next;
                            cnt       <= '0;
                            tidx      <= 1'b0;
                            st        <= is_wr ? ST_DATA : ST_TURN_A;
                        end
                    end
                    ST_TURN_A, ST_TURN_B: begin
                        fld_valid <= 1'b1;
                        fld_kind  <= FK_TURN;
                        fld_value <= VAL_W'({tidx, bus_nib});
                        warn.turn <= (bus_nib != TURN_IDLE);
                        tidx      <= ~tidx;
                        if (tidx) begin
                            scnt <= '0;
                            st   <= (st == ST_TURN_A) ? ST_SYNC : ST_IDLE;
                        end
                    end
                    ST_SYNC: begin
                        fld_valid <= 1'b1;
                        fld_kind  <= FK_SYNC;
                        fld_value <= VAL_W'({scnt, bus_nib});
                        if (sy_now == SY_DONE) begin
                            cnt  <= '0;
                            tidx <= 1'b0;
                            st   <= is_wr ? ST_TURN_B : ST_DATA;
                        end else begin
                            warn.badsync <= (sy_now == SY_RSVD);
                            if (scnt != '1) scnt <= scnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == '0) begin
                            lo_nib <= bus_nib;
                            cnt    <= CNT_W'(1);
                        end else begin
                            fld_valid <= 1'b1;
                            fld_kind  <= FK_DATA;
                            fld_value <= VAL_W'({bus_nib, lo_nib});
                            cnt       <= '0;
                            tidx      <= 1'b0;
                            st        <= is_wr ? ST_TURN_A : ST_TURN_B;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/lpc_txn_monitor.sv
module lpc_txn_monitor
    import lpc_mon_pkg::*;
#(
    parameter int IO_NIBBLES  = 4,
    parameter int MEM_NIBBLES = 8,
    parameter int SYNC_CNT_W  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic [3:0]  bus_nib,
    output logic        fld_valid,
    output logic [2:0]  fld_kind,
    output logic [31:0] fld_value,
    output logic        warn_unstable,
    output logic        warn_badtype,
    output logic        warn_turn,
    output logic        warn_badsync,
    output logic        abort_seen
);

    logic      frame_act;
    logic      nib_changed;
    fld_kind_e kind_w;
    warn_t     warn_w;

    lpc_mon_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .bus_nib    (bus_nib),
        .frame_act  (frame_act),
        .nib_changed(nib_changed)
    );

    lpc_mon_walker #(
        .IO_NIBBLES (IO_NIBBLES),
        .MEM_NIBBLES(MEM_NIBBLES),
        .SYNC_CNT_W (SYNC_CNT_W)
    ) u_walker (
        .clk        (clk),
        .rst        (rst),
        .frame_act  (frame_act),
        .nib_changed(nib_changed),
        .bus_nib    (bus_nib),
        .fld_valid  (fld_valid),
        .fld_kind   (kind_w),
        .fld_value  (fld_value),
        .warn       (warn_w)
    );

    assign fld_kind      = kind_w;
    assign warn_unstable = warn_w.unstable;
    assign warn_badtype  = warn_w.badtype;
    assign warn_turn     = warn_w.turn;
    assign warn_badsync  = warn_w.badsync;
    assign abort_seen    = warn_w.abort;

endmodule

// File: rtl/lpc_txn_monitor_chk.sv
module lpc_txn_monitor_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_n,
    input logic        fld_valid,
    input logic [2:0]  fld_kind,
    input logic [31:0] fld_value,
    input logic        warn_unstable,
    input logic        warn_badtype,
    input logic        warn_turn,
    input logic        warn_badsync,
    input logic        abort_seen
);

    assert_start_report_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (fld_valid && fld_kind == 3'd0));

    assert_unstable_on_start_R3: assert property (@(posedge clk) disable iff (rst)
        warn_unstable |-> (fld_valid && fld_kind == 3'd0));

    assert_badtype_on_ctype_R5: assert property (@(posedge clk) disable iff (rst)
        warn_badtype |-> (fld_valid && fld_kind == 3'd1));

    assert_turn_flag_value_R7: assert property (@(posedge clk) disable iff (rst)
        warn_turn |-> (fld_valid && fld_kind == 3'd3 && fld_value[3:0] != 4'hF));

    assert_turn_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (fld_valid && fld_kind == 3'd3 && fld_value[3:0] == 4'hF) |-> !warn_turn);

    assert_badsync_on_sync_R8: assert property (@(posedge clk) disable iff (rst)
        warn_badsync |-> (fld_valid && fld_kind == 3'd4));

    assert_abort_on_start_R11: assert property (@(posedge clk) disable iff (rst)
        abort_seen |-> (fld_valid && fld_kind == 3'd0));

    assert_one_field_warn_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({warn_badtype, warn_turn, warn_badsync}));

endmodule

bind lpc_txn_monitor lpc_txn_monitor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_n      (frame_n),
    .fld_valid    (fld_valid),
    .fld_kind     (fld_kind),
    .fld_value    (fld_value),
    .warn_unstable(warn_unstable),
    .warn_badtype (warn_badtype),
    .warn_turn    (warn_turn),
    .warn_badsync (warn_badsync),
    .abort_seen   (abort_seen)
);

// File: tb/lpc_txn_monitor_bench.sv
module lpc_txn_monitor_bench;

    localparam logic [2:0] K_START = 3'd0, K_CTYPE = 3'd1, K_ADDR = 3'd2,
                           K_TURN  = 3'd3, K_SYNC  = 3'd4, K_DATA = 3'd5;
    localparam logic [4:0] F_NONE = 5'b00000, F_UNS = 5'b10000, F_BT = 5'b01000,
                           F_TRN  = 5'b00100, F_BSY = 5'b00010, F_ABT = 5'b00001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_nib = 4'hF;
    logic        fld_valid;
    logic [2:0]  fld_kind;
    logic [31:0] fld_value;
    logic        warn_unstable, warn_badtype, warn_turn, warn_badsync, abort_seen;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpc_txn_monitor u_lpc_txn_monitor (
        .clk          (clk),
        .rst          (rst),
        .frame_n      (frame_n),
        .bus_nib      (bus_nib),
        .fld_valid    (fld_valid),
        .fld_kind     (fld_kind),
        .fld_value    (fld_value),
        .warn_unstable(warn_unstable),
        .warn_badtype (warn_badtype),
        .warn_turn    (warn_turn),
        .warn_badsync (warn_badsync),
        .abort_seen   (abort_seen)
    );

    function automatic logic [4:0] flags_now();
        return {warn_unstable, warn_badtype, warn_turn, warn_badsync, abort_seen};
    endfunction

    // Drive one bus clock, then compare the report that edge produced.
    task automatic step(input logic fr, input logic [3:0] nb, input logic ev,
                        input logic [2:0] ek, input logic [31:0] evl,
                        input logic [4:0] ef, input string req);
        logic ok;
        frame_n = fr;
        bus_nib = nb;
        @(posedge clk);
        #1;
        checks++;
        ok = (fld_valid == ev) && (flags_now() == ef) &&
             (!ev || (fld_kind == ek && fld_value == evl));
        if (!ok) begin
            errors++;
            $display("FAIL %s: got v=%0b k=%0d val=%h f=%b, expected v=%0b k=%0d val=%h f=%b",
                     req, fld_valid, fld_kind, fld_value, flags_now(), ev, ek, evl, ef);
        end
    endtask

    function automatic logic [4:0] turn_flag(input logic [3:0] n);
        return (n != 4'hF) ? F_TRN : F_NONE;
    endfunction

    task automatic do_turn(input logic [3:0] n0, input logic [3:0] n1);
        step(1'b1, n0, 1'b1, K_TURN, {27'd0, 1'b0, n0}, turn_flag(n0), "R7");
        step(1'b1, n1, 1'b1, K_TURN, {27'd0, 1'b1, n1}, turn_flag(n1), "R7");
    endtask

    task automatic do_sync(input int waits, input logic [3:0] endn);
        for (int i = 0; i < waits; i++) begin
            logic [3:0] w;
            w = (i % 2 == 1) ? 4'b0110 : 4'b0101;
            step(1'b1, w, 1'b1, K_SYNC, 32'(i * 16) + 32'(w), F_NONE, "R8");
        end
        step(1'b1, endn, 1'b1, K_SYNC, 32'(waits * 16) + 32'(endn), F_NONE, "R8");
    endtask

    task automatic do_data(input logic [7:0] d);
        step(1'b1, d[3:0], 1'b0, K_DATA, 32'd0, F_NONE, "R9");
        step(1'b1, d[7:4], 1'b1, K_DATA, {24'd0, d}, F_NONE, "R9");
    endtask

    task automatic do_ctype_addr(input logic mem, input logic wr, input logic [31:0] addr);
        logic [3:0] ct;
        int n;
        ct = {1'b0, mem, wr, 1'b0};
        step(1'b1, ct, 1'b1, K_CTYPE, {28'd0, ct}, F_NONE, "R5");
        n = mem ? 8 : 4;
        for (int i = 0; i < n; i++) begin
            logic [3:0] nb;
            nb = addr[(n - 1 - i) * 4 +: 4];
            if (i == n - 1)
                step(1'b1, nb, 1'b1, K_ADDR, mem ? addr : {16'd0, addr[15:0]}, F_NONE, "R6");
            else
                step(1'b1, nb, 1'b0, K_ADDR, 32'd0, F_NONE, "R6");
        end
    endtask

    task automatic run_txn(input int nstart, input logic mem, input logic wr,
                           input logic [31:0] addr, input logic [7:0] d,
                           input int waits, input logic [3:0] endn, input logic [3:0] tb0);
        for (int i = 0; i < nstart; i++)
            step(1'b0, 4'h0, 1'b1, K_START, 32'd0, F_NONE, "R2");
        do_ctype_addr(mem, wr, addr);
        if (!wr) begin
            do_turn(tb0, 4'hF);
            do_sync(waits, endn);
            do_data(d);
        end else begin
            do_data(d);
            do_turn(tb0, 4'hF);
            do_sync(waits, endn);
        end
        do_turn(4'hF, 4'hF);
        step(1'b1, 4'hF, 1'b0, K_START, 32'd0, F_NONE, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C0DE5));
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (fld_valid || fld_value != 0 || flags_now() != 0) begin
            errors++;
            $display("FAIL R1: got v=%0b val=%h f=%b, expected all zero",
                     fld_valid, fld_value, flags_now());
        end
        rst = 1'b0;
        step(1'b1, 4'hF, 1'b0, K_START, 32'd0, F_NONE, "R1");

        // Plain I/O read and memory write.
        run_txn(1, 1'b0, 1'b0, 32'h0000_1234, 8'hA5, 2, 4'b0000, 4'hF);
        run_txn(1, 1'b1, 1'b1, 32'hDEAD_BEEF, 8'h3C, 0, 4'b0000, 4'hF);

        // R3: framing nibble changes while the strobe stays low; last nibble is target.
        step(1'b0, 4'h3, 1'b1, K_START, 32'd3, F_NONE, "R2");
        step(1'b0, 4'h0, 1'b1, K_START, 32'd0, F_UNS, "R3");
        run_txn(1, 1'b1, 1'b0, 32'h8000_0010, 8'h5A, 1, 4'b1010, 4'hF);

        // R4: last framing nibble is not the target code.
        step(1'b0, 4'h0, 1'b1, K_START, 32'd0, F_NONE, "R2");
        step(1'b0, 4'h2, 1'b1, K_START, 32'd2, F_UNS, "R3");
        step(1'b1, 4'h0, 1'b0, K_START, 32'd0, F_NONE, "R4");
        step(1'b1, 4'hF, 1'b0, K_START, 32'd0, F_NONE, "R4");

        // R5: invalid cycle type.
        step(1'b0, 4'h0, 1'b1, K_START, 32'd0, F_NONE, "R2");
        step(1'b1, 4'b1000, 1'b1, K_CTYPE, 32'd8, F_BT, "R5");
        step(1'b1, 4'h0, 1'b0, K_START, 32'd0, F_NONE, "R5");

        // R5: bit 0 of the type is ignored (I/O read).
        step(1'b0, 4'h0, 1'b1, K_START, 32'd0, F_NONE, "R2");
        step(1'b1, 4'b0001, 1'b1, K_CTYPE, 32'd1, F_NONE, "R5");
        step(1'b1, 4'h0, 1'b0, K_ADDR, 32'd0, F_NONE, "R6");
        step(1'b1, 4'h0, 1'b0, K_ADDR, 32'd0, F_NONE, "R6");
        step(1'b1, 4'h8, 1'b0, K_ADDR, 32'd0, F_NONE, "R6");
        step(1'b1, 4'h0, 1'b1, K_ADDR, 32'h0000_0080, F_NONE, "R6");
        do_turn(4'hF, 4'hF);
        // R8: reserved SYNC code in the middle of waits.
        step(1'b1, 4'b0101, 1'b1, K_SYNC, 32'h05, F_NONE, "R8");
        step(1'b1, 4'b0011, 1'b1, K_SYNC, 32'h13, F_BSY, "R8");
        step(1'b1, 4'b0000, 1'b1, K_SYNC, 32'h20, F_NONE, "R8");
        do_data(8'hC3);
        do_turn(4'hF, 4'hF);
        step(1'b1, 4'hF, 1'b0, K_START, 32'd0, F_NONE, "R10");

        // R7: bad first turn-around nibble.
        run_txn(1, 1'b0, 1'b1, 32'h0000_00F0, 8'h11, 3, 4'b0000, 4'h7);

        // R11: abort during the address.
        step(1'b0, 4'h0, 1'b1, K_START, 32'd0, F_NONE, "R2");
        step(1'b1, 4'b0100, 1'b1, K_CTYPE, 32'd4, F_NONE, "R5");
        step(1'b1, 4'h1, 1'b0, K_ADDR, 32'd0, F_NONE, "R6");
        step(1'b1, 4'h2, 1'b0, K_ADDR, 32'd0, F_NONE, "R6");
        step(1'b0, 4'h0, 1'b1, K_START, 32'd0, F_ABT, "R11");
        run_txn(1, 1'b0, 1'b0, 32'h0000_BEEF, 8'h77, 0, 4'b0000, 4'hF);

        // Random transactions.
        for (int t = 0; t < 60; t++) begin
            logic mem, wr;
            logic [31:0] a;
            logic [7:0] d;
            int ns, w;
            logic [3:0] en;
            mem = 1'($urandom_range(0, 1));
            wr  = 1'($urandom_range(0, 1));
            a   = $urandom();
            d   = 8'($urandom());
            ns  = $urandom_range(1, 3);
            w   = $urandom_range(0, 5);
            en  = ($urandom_range(0, 3) == 0) ? 4'b1010 : 4'b0000;
            run_txn(ns, mem, wr, a, d, w, en, 4'hF);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule